// File: doc/BRIEF.md
# Pointer Register Address Generator

This block produces the memory address for the indirect data accesses, program-memory loads, stack operations and I/O accesses of a small 8-bit processor core. A start strobe brings in an operation class, an addressing mode, a pointer select and a 6-bit displacement. At that same edge the block takes a snapshot of the chosen 16-bit pointer (Y, Z or the stack pointer). It then walks through the fixed cycle count of that operation. On the final busy cycle it raises a memory strobe and gives the new pointer value with its write-back enable.

The register file, the data and program memories and the instruction decoder sit outside the block. The register file supplies the pointer values and takes the write-back. The memories act on the strobe. One cycle after the final busy cycle the block pulses `done_o`, and it accepts a new operation in that same cycle.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_stb_o`, `ptr_we_o` and `dst_r0_o` are all low.
- R2: Data access (op_i=0) with mode_i=2 (pre-decrement) puts the selected pointer minus one on `addr_o`. It writes that same value back: `ptr_dst_o`=0 for Y (ptr_sel_i=0) or 1 for Z (ptr_sel_i=1).
- R3: Data access with mode_i=1 (post-increment) puts the selected pointer itself on `addr_o` and writes back the pointer plus one.
- R4: Data access with mode_i=3 (displacement) addresses the pointer plus the zero-extended 6-bit `disp_i` and writes nothing back. With mode_i=0 (plain) it addresses the pointer and writes nothing back.
- R5: `busy_o` stays high for exactly 2 cycles for a data access (op 0), push (op 2), pop (op 3) and I/O bit operation (op 5). It stays high for 3 cycles for a program-memory load (op 1) and for 1 cycle for a plain I/O access (op 4; codes 6 and 7 act as op 4).
- R6: A program-memory load always uses Z, whatever ptr_sel_i is, and raises `pmem_o`. With mode_i=1 it writes Z+1 back to Z (ptr_dst_o=1). With any other mode it writes nothing back. `dst_r0_o` is raised on the strobe cycle when `no_dst_i` was high at start.
- R7: A push addresses SP and writes SP-1. A pop addresses SP+1 and writes SP+1. Both use ptr_dst_o=2.
- R8: All pointer and address arithmetic wraps modulo 65536.
- R9: `mem_stb_o` and any `ptr_we_o` occur only on the final busy cycle. `done_o` is high for exactly the one cycle after it.
- R10: A start while busy is ignored: the running operation's address, outputs and length are unchanged.
- R11: I/O operations (op 4 and 5) address the zero-extended `disp_i` in data space and never write back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 3 | Operation class: 0 data, 1 program load, 2 push, 3 pop, 4 I/O, 5 I/O bit |
| mode_i | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ptr_sel_i | input | 1 | 0 selects Y, 1 selects Z for data access |
| disp_i | input | 6 | Displacement q, or I/O address |
| no_dst_i | input | 1 | Program load names no destination |
| y_i | input | 16 | Current Y pointer |
| z_i | input | 16 | Current Z pointer |
| sp_i | input | 16 | Current stack pointer |
| busy_o | output | 1 | Operation in progress |
| addr_o | output | 16 | Effective address |
| pmem_o | output | 1 | Address targets program memory |
| mem_stb_o | output | 1 | Memory access strobe, final busy cycle |
| ptr_we_o | output | 1 | Pointer write-back enable |
| ptr_dst_o | output | 2 | Write-back target: 0 Y, 1 Z, 2 SP |
| ptr_val_o | output | 16 | Updated pointer value |
| dst_r0_o | output | 1 | Program load result goes to R0 |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The start is taken at clock edge E0, and `busy_o` is high after edges E0 to E(N-1), where N is the operation's cycle count. The strobe, address, write-back and R0 flag are due after edge E(N-1), and `done_o` after edge EN. The bench drives inputs and samples outputs on falling edges. At each falling edge it compares the cycle index with N, so it checks busy and the absence of a strobe on every earlier cycle and checks the whole result only at the expected cycle. Extra starts are driven during the first busy cycle, and the pointer inputs are changed while busy, to show that the snapshot and the count still hold.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  localparam int AW     = 16;
  localparam int DW     = 6;
  localparam int MAXCYC = 3;
  localparam int CW     = $clog2(MAXCYC + 1);

  typedef enum logic [2:0] {
    OP_DATA = 3'd0, OP_PROG = 3'd1, OP_PUSH = 3'd2, OP_POP = 3'd3,
    OP_IO   = 3'd4, OP_IOBIT = 3'd5, OP_RSV6 = 3'd6, OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    AM_PLAIN = 2'd0, AM_POST = 2'd1, AM_PRE = 2'd2, AM_DISP = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    DST_Y = 2'd0, DST_Z = 2'd1, DST_SP = 2'd2
  } dst_e;

  function automatic logic [CW-1:0] op_cycles(op_e op);
    case (op)
      OP_DATA, OP_PUSH, OP_POP, OP_IOBIT: op_cycles = CW'(2);
      OP_PROG:                            op_cycles = CW'(3);
      default:                            op_cycles = CW'(1);
    endcase
  endfunction
endpackage

// File: rtl/pag_seq.sv
module pag_seq
  import ptr_addr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] cycles_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          last_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign accept_o = start_i & ~busy_q;
  assign busy_o   = busy_q;
  assign last_o   = busy_q & (cnt_q == '0);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= cycles_i - CW'(1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pag_ea_calc.sv
module pag_ea_calc
  import ptr_addr_pkg::*;
(
  input  op_e           op_i,
  input  amode_e        mode_i,
  input  logic          sel_z_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o,
  output logic          pmem_o,
  output logic          we_o,
  output dst_e          dst_o,
  output logic [AW-1:0] val_o
);
  logic [AW-1:0] inc, dec, dsp;

  // all sums truncate to AW bits: modulo wrap
  assign inc = base_i + AW'(1);
  assign dec = base_i - AW'(1);
  assign dsp = base_i + AW'(disp_i);

  always_comb begin
    addr_o = base_i;
    pmem_o = 1'b0;
    we_o   = 1'b0;
    dst_o  = sel_z_i ? DST_Z : DST_Y;
    val_o  = base_i;
    case (op_i)
      OP_DATA: begin
        case (mode_i)
          AM_POST: begin we_o = 1'b1; val_o = inc; end
          AM_PRE:  begin we_o = 1'b1; val_o = dec; addr_o = dec; end
          AM_DISP: addr_o = dsp;
          default: ;
        endcase
      end
      OP_PROG: begin
        pmem_o = 1'b1;
        dst_o  = DST_Z;
        if (mode_i == AM_POST) begin
          we_o  = 1'b1;
          val_o = inc;
        end
      end
      OP_PUSH: begin dst_o = DST_SP; we_o = 1'b1; val_o = dec; end
      OP_POP:  begin dst_o = DST_SP; we_o = 1'b1; val_o = inc; addr_o = inc; end
      default: addr_o = AW'(disp_i);
    endcase
  end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_addr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    mode_i,
  input  logic          ptr_sel_i,
  input  logic [5:0]    disp_i,
  input  logic          no_dst_i,
  input  logic [15:0]   y_i,
  input  logic [15:0]   z_i,
  input  logic [15:0]   sp_i,
  output logic          busy_o,
  output logic [15:0]   addr_o,
  output logic          pmem_o,
  output logic          mem_stb_o,
  output logic          ptr_we_o,
  output logic [1:0]    ptr_dst_o,
  output logic [15:0]   ptr_val_o,
  output logic          dst_r0_o,
  output logic          done_o
);
  op_e           op_q;
  amode_e        mode_q;
  logic          sel_q, nodst_q;
  logic [DW-1:0] disp_q;
  logic [AW-1:0] base_q, base_d;
  logic          accept, last, we;
  dst_e          dst;

  always_comb begin
    case (op_e'(op_i))
      OP_DATA:         base_d = ptr_sel_i ? z_i : y_i;
      OP_PROG:         base_d = z_i;
      OP_PUSH, OP_POP: base_d = sp_i;
      default:         base_d = '0;
    endcase
  end

  pag_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .cycles_i (op_cycles(op_e'(op_i))),
    .accept_o (accept),
    .busy_o   (busy_o),
    .last_o   (last),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_IO;
      mode_q  <= AM_PLAIN;
      sel_q   <= 1'b0;
      nodst_q <= 1'b0;
      disp_q  <= '0;
      base_q  <= '0;
    end else if (accept) begin
      op_q    <= op_e'(op_i);
      mode_q  <= amode_e'(mode_i);
      sel_q   <= ptr_sel_i;
      nodst_q <= no_dst_i;
      disp_q  <= disp_i;
      base_q  <= base_d;
    end
  end

  pag_ea_calc u_ea (
    .op_i    (op_q),
    .mode_i  (mode_q),
    .sel_z_i (sel_q),
    .disp_i  (disp_q),
    .base_i  (base_q),
    .addr_o  (addr_o),
    .pmem_o  (pmem_o),
    .we_o    (we),
    .dst_o   (dst),
    .val_o   (ptr_val_o)
  );

  assign mem_stb_o = last;
  assign ptr_we_o  = last & we;
  assign ptr_dst_o = dst;
  assign dst_r0_o  = last & nodst_q & (op_q == OP_PROG);
endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk
  import ptr_addr_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic [AW-1:0] addr_o,
  input logic          pmem_o,
  input logic          mem_stb_o,
  input logic          ptr_we_o,
  input logic [1:0]    ptr_dst_o,
  input logic [AW-1:0] ptr_val_o,
  input logic          done_o,
  input op_e           op_q,
  input amode_e        mode_q
);
  p_we_on_stb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_o |-> mem_stb_o);
  p_stb_then_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_stb_o |=> done_o);
  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_hold_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_stb_o) |=> (busy_o && $stable(addr_o)));
  p_disp_no_wb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_stb_o && op_q == OP_DATA && mode_q == AM_DISP) |-> !ptr_we_o);
  p_predec_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_o && op_q == OP_DATA && mode_q == AM_PRE) |-> addr_o == ptr_val_o);
  p_postinc_val_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_o && op_q == OP_DATA && mode_q == AM_POST) |-> ptr_val_o == AW'(addr_o + AW'(1)));
  p_push_sp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_we_o && op_q == OP_PUSH) |-> (ptr_val_o == AW'(addr_o - AW'(1)) && ptr_dst_o == 2'd2));
  p_prog_space_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_stb_o && op_q == OP_PROG) |-> pmem_o);
  p_io_no_wb_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_stb_o && (op_q == OP_IO || op_q == OP_IOBIT)) |-> (!ptr_we_o && !pmem_o));
endmodule

bind ptr_addr_gen ptr_addr_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .addr_o    (addr_o),
  .pmem_o    (pmem_o),
  .mem_stb_o (mem_stb_o),
  .ptr_we_o  (ptr_we_o),
  .ptr_dst_o (ptr_dst_o),
  .ptr_val_o (ptr_val_o),
  .done_o    (done_o),
  .op_q      (op_q),
  .mode_q    (mode_q)
);

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, sel = 1'b0, nodst = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  mode = '0;
  logic [5:0]  disp = '0;
  logic [15:0] y = '0, z = '0, sp = '0;
  logic        busy, pmem, stb, we, r0, done;
  logic [15:0] addr, val;
  logic [1:0]  dst;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .mode_i(mode),
    .ptr_sel_i(sel), .disp_i(disp), .no_dst_i(nodst), .y_i(y), .z_i(z), .sp_i(sp),
    .busy_o(busy), .addr_o(addr), .pmem_o(pmem), .mem_stb_o(stb), .ptr_we_o(we),
    .ptr_dst_o(dst), .ptr_val_o(val), .dst_r0_o(r0), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int n_cyc(logic [2:0] o);
    if (o == 3'd1) return 3;
    if (o == 3'd0 || o == 3'd2 || o == 3'd3 || o == 3'd5) return 2;
    return 1;
  endfunction

  // expected results from requirements R2..R8, R11
  task automatic expect_of(input logic [2:0] o, input logic [1:0] m, input logic s,
      input logic [5:0] q, input logic [15:0] yv, input logic [15:0] zv, input logic [15:0] spv,
      output logic [15:0] ea, output logic pm, output logic wb, output logic [1:0] d,
      output logic [15:0] nv);
    logic [15:0] p;
    p = s ? zv : yv;
    pm = 1'b0; wb = 1'b0; d = {1'b0, s}; nv = p; ea = p;
    case (o)
      3'd0: case (m)
        2'd1: begin wb = 1'b1; nv = p + 16'd1; end
        2'd2: begin wb = 1'b1; nv = p - 16'd1; ea = p - 16'd1; end
        2'd3: ea = p + {10'd0, q};
        default: ;
      endcase
      3'd1: begin pm = 1'b1; d = 2'd1; ea = zv; nv = zv;
        if (m == 2'd1) begin wb = 1'b1; nv = zv + 16'd1; end end
      3'd2: begin d = 2'd2; wb = 1'b1; ea = spv; nv = spv - 16'd1; end
      3'd3: begin d = 2'd2; wb = 1'b1; ea = spv + 16'd1; nv = spv + 16'd1; end
      default: ea = {10'd0, q};
    endcase
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] m, input logic s,
      input logic [5:0] q, input logic nd, input logic [15:0] yv, input logic [15:0] zv,
      input logic [15:0] spv, input bit junk);
    logic [15:0] ea, nv; logic pm, wb; logic [1:0] d;
    int n;
    n = n_cyc(o);
    expect_of(o, m, s, q, yv, zv, spv, ea, pm, wb, d, nv);
    op = o; mode = m; sel = s; disp = q; nodst = nd; y = yv; z = zv; sp = spv;
    start = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) begin
        start = junk && n > 1;
        op = 3'($urandom_range(0, 7)); mode = 2'($urandom); disp = 6'($urandom);
        y = 16'($urandom); z = 16'($urandom); sp = 16'($urandom); sel = ~s; nodst = ~nd;
      end else start = 1'b0;
      chk("R5 busy", busy, 1'b1);
      chk("R9 strobe timing", stb, (k == n - 1));
      if (k == n - 1) begin
        chk("R2/R3/R4/R6/R7/R8/R11 addr", addr, ea);
        chk("R6 pmem", pmem, pm);
        chk("R9 write-back enable", we, wb);
        if (wb) begin
          chk("R2/R3/R7 dst", dst, d);
          chk("R2/R3/R6/R7/R8 value", val, nv);
        end
        chk("R6 r0 dest", r0, (o == 3'd1) && nd);
        chk("R10 done low while busy", done, 1'b0);
      end else begin
        chk("R9 no write before last", we, 1'b0);
      end
    end
    @(negedge clk);
    chk("R9 done pulse", done, 1'b1);
    chk("R5 busy ends", busy, 1'b0);
    chk("R9 no strobe after", stb, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("R1 busy reset", busy, 1'b0);
    chk("R1 done reset", done, 1'b0);
    chk("R1 strobe reset", stb, 1'b0);
    chk("R1 we reset", we, 1'b0);
    chk("R1 r0 reset", r0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_op(3'd0, 2'd2, 1'b0, 6'd0, 1'b0, 16'h0000, 16'h1234, 16'h0100, 1'b1); // R2 R8
    run_op(3'd0, 2'd2, 1'b1, 6'd0, 1'b0, 16'h5555, 16'h8000, 16'h0100, 1'b0); // R2
    run_op(3'd0, 2'd1, 1'b1, 6'd0, 1'b0, 16'h0000, 16'hFFFF, 16'h0100, 1'b1); // R3 R8
    run_op(3'd0, 2'd3, 1'b0, 6'd63, 1'b0, 16'hFFF0, 16'h0000, 16'h0100, 1'b1); // R4 R8
    run_op(3'd0, 2'd0, 1'b1, 6'd9, 1'b0, 16'h0001, 16'h4321, 16'h0100, 1'b0); // R4 plain
    run_op(3'd1, 2'd0, 1'b0, 6'd0, 1'b1, 16'h1111, 16'h0200, 16'h0100, 1'b1); // R6
    run_op(3'd1, 2'd1, 1'b0, 6'd0, 1'b0, 16'h1111, 16'hFFFF, 16'h0100, 1'b0); // R6 R8
    run_op(3'd2, 2'd0, 1'b0, 6'd0, 1'b0, 16'h0, 16'h0, 16'h0000, 1'b1);        // R7 R8
    run_op(3'd3, 2'd0, 1'b0, 6'd0, 1'b0, 16'h0, 16'h0, 16'hFFFF, 1'b1);        // R7 R8
    run_op(3'd4, 2'd2, 1'b1, 6'd31, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0);         // R11
    run_op(3'd5, 2'd1, 1'b0, 6'd63, 1'b0, 16'h0, 16'h0, 16'h0, 1'b1);         // R11 R10
    run_op(3'd7, 2'd1, 1'b0, 6'd5, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0);          // R5 R11
    // constrained random
    for (int i = 0; i < 400; i++) begin
      run_op(3'($urandom_range(0, 7)), 2'($urandom), 1'($urandom), 6'($urandom),
             1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
      if (($urandom & 3) == 0) @(negedge clk);
    end
    finish_run();
  end
endmodule